// File: doc/BRIEF.md
# Mixed-Width True Dual-Port RAM

The block is an 18 Kbit synchronous memory with two fully independent ports over the same storage. The storage holds 16 Kbit of data and 2 Kbit of parity. Each port has its own clock, enable, write enable, synchronous output reset, address, write data, write parity, read data and read parity. Each port picks its word width from a fixed set of aspect ratios by parameter, and the two ports may use different widths. A narrow port addresses slices inside the words that a wide port sees.

Each port also picks by parameter how its output register behaves during a write. It can take the data being written, take the old contents, or keep its value. Each port also picks which clock edge is active. All outputs come from registers: read data appears one active edge after the request. The data pins are plain memory pins with no valid/ready handshake. A request is accepted on every active edge on which the port is enabled, so the block has no back-pressure.

Top module: `tdp_mixed_ram`

## Requirements
- R1: WIDTH of 1, 2, 4, 9, 18 or 36 gives 16384, 8192, 4096, 2048, 1024 or 512 locations, addressed by 14, 13, 12, 11, 10 or 9 bits. A 36-bit word is parity[3:0] over data[31:0]. For a narrower port, the address bits above the slice field pick the 36-bit word and the low address bits pick a slice. Slice 0 is the least significant data bits, and parity is sliced the same way.
- R2: Widths 9, 18 and 36 carry 1, 2 and 4 parity bits beside 8, 16 and 32 data bits. Widths 1, 2 and 4 have a 1-bit parity input that is ignored and a parity output that stays 0.
- R3: With enable high and write enable low, an active edge loads the addressed word into the output registers.
- R4: In write-first mode, a write edge loads the written data and parity into the output registers.
- R5: In read-first mode, a write edge loads the contents the location held before the write.
- R6: In no-change mode, a write edge leaves the output registers unchanged.
- R7: With enable low, an active edge changes neither the memory nor the output registers of that port.
- R8: Synchronous reset with enable high loads the port's parameterized reset value into its outputs and takes priority over read data. It does not block or alter a write on the same edge.
- R9: Each port acts only on its own selected clock edge: rising when its NEG_EDGE parameter is 0, falling when it is 1.
- R10: At start-up the output registers hold the reset values and every memory bit is 0.
- R11: Two writes to the same bits on one cycle, or a read of bits the other port is writing, give undefined data. Users must avoid these cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| srst_a | input | 1 | Port A synchronous output reset |
| addr_a | input | AW_A | Port A address |
| din_a | input | DW_A | Port A write data |
| pin_a | input | PWP_A | Port A write parity (ignored without parity) |
| dout_a | output | DW_A | Port A registered read data |
| pout_a | output | PWP_A | Port A registered read parity |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| srst_b | input | 1 | Port B synchronous output reset |
| addr_b | input | AW_B | Port B address |
| din_b | input | DW_B | Port B write data |
| pin_b | input | PWP_B | Port B write parity (ignored without parity) |
| dout_b | output | DW_B | Port B registered read data |
| pout_b | output | PWP_B | Port B registered read parity |

## Verification
A wrong slice mapping or a lost write shows up on the very next read of that location, from either port. A narrow-to-wide or wide-to-narrow readback therefore exposes a misplaced slice one active edge after the read is issued. A wrong output-register policy shows on the edge of the write itself, as a value that differs from the written data, from the old data or from the held value. A wrong edge selection or broken enable gating shows within half a clock period, as an output that moves on the wrong edge or while the port is disabled.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;

  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

  localparam int WORD_BITS = 36;
  localparam int DATA_BITS = 32;
  localparam int NWORDS    = 512;
  localparam int WIDX      = 9;

  function automatic int data_w(input int w);
    return (w >= 9) ? (w / 9) * 8 : w;
  endfunction

  function automatic int par_w(input int w);
    return (w >= 9) ? (w / 9) : 0;
  endfunction

  function automatic int par_pins(input int w);
    return (par_w(w) == 0) ? 1 : par_w(w);
  endfunction

  function automatic int ratio(input int w);
    return DATA_BITS / data_w(w);
  endfunction

  function automatic int addr_w(input int w);
    return $clog2(NWORDS * ratio(w));
  endfunction

endpackage

// File: rtl/tdp_ram_lane.sv
module tdp_ram_lane #(
  parameter int WIDTH = 36,
  localparam int DW  = tdp_ram_pkg::data_w(WIDTH),
  localparam int PW  = tdp_ram_pkg::par_w(WIDTH),
  localparam int PWP = tdp_ram_pkg::par_pins(WIDTH)
) (
  input  logic [5:0]     sl,
  input  logic [DW-1:0]  din,
  input  logic [PWP-1:0] pin,
  input  logic [35:0]    cur_word,
  output logic [35:0]    wr_word,
  output logic [35:0]    wr_mask,
  output logic [DW-1:0]  rd_d,
  output logic [PWP-1:0] rd_p
);
  localparam int DBASE = tdp_ram_pkg::DATA_BITS;

  logic [35:0] d_word, d_mask;

  always_comb begin
    d_word = '0;
    d_mask = '0;
    d_word[int'(sl) * DW +: DW] = din;
    d_mask[int'(sl) * DW +: DW] = '1;
    rd_d = cur_word[int'(sl) * DW +: DW];
  end

  generate
    if (PW > 0) begin : g_par
      always_comb begin
        wr_word = d_word;
        wr_mask = d_mask;
        wr_word[DBASE + int'(sl) * PW +: PW] = pin;
        wr_mask[DBASE + int'(sl) * PW +: PW] = '1;
        rd_p = cur_word[DBASE + int'(sl) * PW +: PW];
      end
    end else begin : g_nopar
      logic unused_pin;
      assign unused_pin = ^pin;
      assign wr_word = d_word;
      assign wr_mask = d_mask;
      assign rd_p    = '0;
    end
  endgenerate

endmodule

// File: rtl/tdp_ram_port.sv
module tdp_ram_port #(
  parameter int                  WIDTH    = 36,
  parameter tdp_ram_pkg::wmode_e MODE     = tdp_ram_pkg::WM_WRITE_FIRST,
  parameter bit                  NEG_EDGE = 1'b0,
  parameter logic [31:0]         RST_DATA = '0,
  parameter logic [3:0]          RST_PAR  = '0,
  localparam int DW    = tdp_ram_pkg::data_w(WIDTH),
  localparam int PWP   = tdp_ram_pkg::par_pins(WIDTH),
  localparam int PW    = tdp_ram_pkg::par_w(WIDTH),
  localparam int RATIO = tdp_ram_pkg::ratio(WIDTH),
  localparam int SB    = $clog2(RATIO),
  localparam int AW    = tdp_ram_pkg::addr_w(WIDTH),
  localparam int WX    = tdp_ram_pkg::WIDX
) (
  input  logic           clk,
  input  logic           en,
  input  logic           we,
  input  logic           srst,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  din,
  input  logic [PWP-1:0] pin,
  output logic [DW-1:0]  dout,
  output logic [PWP-1:0] pout,
  output logic [WX-1:0]  my_idx,
  input  logic [35:0]    peer_at_mine,
  input  logic [WX-1:0]  peer_idx,
  output logic [35:0]    mine_at_peer
);
  import tdp_ram_pkg::*;

  localparam logic [DW-1:0]  RST_D = RST_DATA[DW-1:0];
  localparam logic [PWP-1:0] RST_P = (PW > 0) ? RST_PAR[PWP-1:0] : '0;

  // Own bank: the stored value of a word is this bank XOR the peer bank.
  logic [35:0] bank [NWORDS] = '{default: '0};
  logic [DW-1:0]  dq = RST_D;
  logic [PWP-1:0] pq = RST_P;

  logic        eclk;
  logic [5:0]  sl;
  logic [35:0] cur_word, wr_word, wr_mask;
  logic [DW-1:0]  rd_d;
  logic [PWP-1:0] rd_p;

  generate
    if (NEG_EDGE) begin : g_fall
      assign eclk = ~clk;
    end else begin : g_rise
      assign eclk = clk;
    end
  endgenerate

  assign my_idx       = WX'(addr >> SB);
  assign sl           = 6'(addr & AW'(RATIO - 1));
  assign cur_word     = bank[my_idx] ^ peer_at_mine;
  assign mine_at_peer = bank[peer_idx];

  tdp_ram_lane #(.WIDTH(WIDTH)) u_lane (
    .sl       (sl),
    .din      (din),
    .pin      (pin),
    .cur_word (cur_word),
    .wr_word  (wr_word),
    .wr_mask  (wr_mask),
    .rd_d     (rd_d),
    .rd_p     (rd_p)
  );

  always_ff @(posedge eclk) begin
    if (en && we) begin
      bank[my_idx] <= bank[my_idx] ^ ((wr_word ^ cur_word) & wr_mask);
    end
  end

  always_ff @(posedge eclk) begin
    if (en) begin
      if (srst) begin
        dq <= RST_D;
        pq <= RST_P;
      end else if (!we || MODE == WM_READ_FIRST) begin
        dq <= rd_d;
        pq <= rd_p;
      end else if (MODE == WM_WRITE_FIRST) begin
        dq <= din;
        pq <= (PW > 0) ? pin : '0;
      end
    end
  end

  assign dout = dq;
  assign pout = pq;

  // R7
  en_low_hold_chk: assert property (@(posedge eclk)
    !en |=> ($stable(dout) && $stable(pout)));

  // R8
  srst_load_chk: assert property (@(posedge eclk)
    (en && srst) |=> (dout == RST_D && pout == RST_P));

  // R4
  wfirst_data_chk: assert property (@(posedge eclk)
    (MODE == WM_WRITE_FIRST && en && we && !srst) |=> (dout == $past(din)));

  // R6
  nochange_hold_chk: assert property (@(posedge eclk)
    (MODE == WM_NO_CHANGE && en && we && !srst) |=> ($stable(dout) && $stable(pout)));

  // R2
  no_par_out_chk: assert property (@(posedge eclk)
    (PW == 0) |-> (pout == '0));

endmodule

// File: rtl/tdp_mixed_ram.sv
module tdp_mixed_ram #(
  parameter int                  WIDTH_A    = 36,
  parameter int                  WIDTH_B    = 9,
  parameter tdp_ram_pkg::wmode_e MODE_A     = tdp_ram_pkg::WM_READ_FIRST,
  parameter tdp_ram_pkg::wmode_e MODE_B     = tdp_ram_pkg::WM_WRITE_FIRST,
  parameter bit                  NEG_EDGE_A = 1'b0,
  parameter bit                  NEG_EDGE_B = 1'b0,
  parameter logic [31:0]         RST_DATA_A = '0,
  parameter logic [3:0]          RST_PAR_A  = '0,
  parameter logic [31:0]         RST_DATA_B = '0,
  parameter logic [3:0]          RST_PAR_B  = '0,
  localparam int AW_A  = tdp_ram_pkg::addr_w(WIDTH_A),
  localparam int DW_A  = tdp_ram_pkg::data_w(WIDTH_A),
  localparam int PWP_A = tdp_ram_pkg::par_pins(WIDTH_A),
  localparam int AW_B  = tdp_ram_pkg::addr_w(WIDTH_B),
  localparam int DW_B  = tdp_ram_pkg::data_w(WIDTH_B),
  localparam int PWP_B = tdp_ram_pkg::par_pins(WIDTH_B)
) (
  input  logic             clk_a,
  input  logic             en_a,
  input  logic             we_a,
  input  logic             srst_a,
  input  logic [AW_A-1:0]  addr_a,
  input  logic [DW_A-1:0]  din_a,
  input  logic [PWP_A-1:0] pin_a,
  output logic [DW_A-1:0]  dout_a,
  output logic [PWP_A-1:0] pout_a,
  input  logic             clk_b,
  input  logic             en_b,
  input  logic             we_b,
  input  logic             srst_b,
  input  logic [AW_B-1:0]  addr_b,
  input  logic [DW_B-1:0]  din_b,
  input  logic [PWP_B-1:0] pin_b,
  output logic [DW_B-1:0]  dout_b,
  output logic [PWP_B-1:0] pout_b
);
  localparam int WX = tdp_ram_pkg::WIDX;

  logic [WX-1:0] idx_a, idx_b;
  logic [35:0]   a_at_b, b_at_a;

  tdp_ram_port #(
    .WIDTH(WIDTH_A), .MODE(MODE_A), .NEG_EDGE(NEG_EDGE_A),
    .RST_DATA(RST_DATA_A), .RST_PAR(RST_PAR_A)
  ) u_port_a (
    .clk(clk_a), .en(en_a), .we(we_a), .srst(srst_a), .addr(addr_a),
    .din(din_a), .pin(pin_a), .dout(dout_a), .pout(pout_a),
    .my_idx(idx_a), .peer_at_mine(b_at_a), .peer_idx(idx_b), .mine_at_peer(a_at_b)
  );

  tdp_ram_port #(
    .WIDTH(WIDTH_B), .MODE(MODE_B), .NEG_EDGE(NEG_EDGE_B),
    .RST_DATA(RST_DATA_B), .RST_PAR(RST_PAR_B)
  ) u_port_b (
    .clk(clk_b), .en(en_b), .we(we_b), .srst(srst_b), .addr(addr_b),
    .din(din_b), .pin(pin_b), .dout(dout_b), .pout(pout_b),
    .my_idx(idx_b), .peer_at_mine(a_at_b), .peer_idx(idx_a), .mine_at_peer(b_at_a)
  );

endmodule

// File: tb/tb_tdp_mixed_ram.sv
module tb_tdp_mixed_ram;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  // dut: A 36-bit read-first rising, B 9-bit write-first falling
  logic en_a = 0, we_a = 0, rs_a = 0; logic [8:0]  ad_a = '0; logic [31:0] di_a = '0; logic [3:0] pi_a = '0;
  logic [31:0] do_a; logic [3:0] po_a;
  logic en_b = 0, we_b = 0, rs_b = 0; logic [10:0] ad_b = '0; logic [7:0]  di_b = '0; logic [0:0] pi_b = '0;
  logic [7:0]  do_b; logic [0:0] po_b;
  // dut2: C 4-bit no-change rising, D 18-bit read-first rising
  logic en_c = 0, we_c = 0, rs_c = 0; logic [11:0] ad_c = '0; logic [3:0]  di_c = '0; logic [0:0] pi_c = '0;
  logic [3:0]  do_c; logic [0:0] po_c;
  logic en_d = 0, we_d = 0, rs_d = 0; logic [9:0]  ad_d = '0; logic [15:0] di_d = '0; logic [1:0] pi_d = '0;
  logic [15:0] do_d; logic [1:0] po_d;

  tdp_mixed_ram #(
    .WIDTH_A(36), .WIDTH_B(9),
    .MODE_A(tdp_ram_pkg::WM_READ_FIRST), .MODE_B(tdp_ram_pkg::WM_WRITE_FIRST),
    .NEG_EDGE_A(1'b0), .NEG_EDGE_B(1'b1),
    .RST_DATA_A(32'hA5A5_5A5A), .RST_PAR_A(4'h9),
    .RST_DATA_B(32'h0000_003C), .RST_PAR_B(4'h1)
  ) dut (
    .clk_a(clk), .en_a(en_a), .we_a(we_a), .srst_a(rs_a), .addr_a(ad_a),
    .din_a(di_a), .pin_a(pi_a), .dout_a(do_a), .pout_a(po_a),
    .clk_b(clk), .en_b(en_b), .we_b(we_b), .srst_b(rs_b), .addr_b(ad_b),
    .din_b(di_b), .pin_b(pi_b), .dout_b(do_b), .pout_b(po_b)
  );

  tdp_mixed_ram #(
    .WIDTH_A(4), .WIDTH_B(18),
    .MODE_A(tdp_ram_pkg::WM_NO_CHANGE), .MODE_B(tdp_ram_pkg::WM_READ_FIRST),
    .NEG_EDGE_A(1'b0), .NEG_EDGE_B(1'b0),
    .RST_DATA_A(32'h0000_0006), .RST_PAR_A(4'h0),
    .RST_DATA_B(32'h0000_BEEF), .RST_PAR_B(4'h2)
  ) dut2 (
    .clk_a(clk), .en_a(en_c), .we_a(we_c), .srst_a(rs_c), .addr_a(ad_c),
    .din_a(di_c), .pin_a(pi_c), .dout_a(do_c), .pout_a(po_c),
    .clk_b(clk), .en_b(en_d), .we_b(we_d), .srst_b(rs_d), .addr_b(ad_d),
    .din_b(di_d), .pin_b(pi_d), .dout_b(do_d), .pout_b(po_d)
  );

  // port index 0..3 = A, B, C, D; mode 0 write-first, 1 read-first, 2 no-change
  int WID  [4] = '{36, 9, 4, 18};
  int MODE [4] = '{1, 0, 2, 1};
  logic [35:0] RSTV [4] = '{{4'h9, 32'hA5A5_5A5A}, {4'h1, 32'h3C}, {4'h0, 32'h6}, {4'h2, 32'hBEEF}};

  logic [35:0] refm [2][512];
  logic [35:0] expo [4];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int dwf(int w); return (w >= 9) ? (w / 9) * 8 : w; endfunction
  function automatic int pwf(int w); return (w >= 9) ? w / 9 : 0; endfunction

  function automatic logic [35:0] get(logic [35:0] wd, int w, int sl);
    logic [35:0] r = '0;
    for (int i = 0; i < dwf(w); i++) r[i] = wd[sl * dwf(w) + i];
    for (int i = 0; i < pwf(w); i++) r[32 + i] = wd[32 + sl * pwf(w) + i];
    return r;
  endfunction

  function automatic logic [35:0] put(logic [35:0] wd, int w, int sl, logic [31:0] d, logic [3:0] p);
    logic [35:0] r = wd;
    for (int i = 0; i < dwf(w); i++) r[sl * dwf(w) + i] = d[i];
    for (int i = 0; i < pwf(w); i++) r[32 + sl * pwf(w) + i] = p[i];
    return r;
  endfunction

  function automatic logic [35:0] rd_act(int p);
    case (p)
      0: return {po_a, do_a};
      1: return {3'b0, po_b, 24'b0, do_b};
      2: return {3'b0, po_c, 28'b0, do_c};
      default: return {2'b0, po_d, 16'b0, do_d};
    endcase
  endfunction

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(int p, bit en, bit we, bit rs, int addr, logic [31:0] d, logic [3:0] pr);
    case (p)
      0: begin en_a = en; we_a = we; rs_a = rs; ad_a = 9'(addr);  di_a = d;        pi_a = pr; end
      1: begin en_b = en; we_b = we; rs_b = rs; ad_b = 11'(addr); di_b = d[7:0];   pi_b = pr[0:0]; end
      2: begin en_c = en; we_c = we; rs_c = rs; ad_c = 12'(addr); di_c = d[3:0];   pi_c = pr[0:0]; end
      default: begin en_d = en; we_d = we; rs_d = rs; ad_d = 10'(addr); di_d = d[15:0]; pi_d = pr[1:0]; end
    endcase
  endtask

  task automatic do_op(int p, bit en, bit we, bit rs, int addr, logic [31:0] d, logic [3:0] pr, string req);
    int w = WID[p];
    int r = 32 / dwf(w);
    int idx = addr / r;
    int sl = addr % r;
    int dv = (p < 2) ? 0 : 1;
    logic [35:0] old;
    @(posedge clk); #1;
    drive(p, en, we, rs, addr, d, pr);
    if (p == 1) @(negedge clk); else @(posedge clk);
    #1;
    drive(p, 0, 0, 0, addr, d, pr);
    old = get(refm[dv][idx], w, sl);
    if (en) begin
      if (rs) expo[p] = RSTV[p];
      else if (!we || MODE[p] == 1) expo[p] = old;
      else if (MODE[p] == 0) expo[p] = get(put('0, w, 0, d, pr), w, 0);
      if (we) refm[dv][idx] = put(refm[dv][idx], w, sl, d, pr);
    end
    chk(req, rd_act(p), expo[p]);
  endtask

  task automatic t_reset_state;
    for (int p = 0; p < 4; p++) chk("R10 start-up output", rd_act(p), RSTV[p]);
  endtask

  task automatic t_wide_rw;
    do_op(0, 1, 1, 0, 3, 32'hDEAD_BEEF, 4'hC, "R5 read-first write of fresh word");
    do_op(0, 1, 1, 0, 3, 32'h1234_5678, 4'h3, "R5 read-first returns prior word");
    do_op(0, 1, 1, 0, 7, 32'hCAFE_F00D, 4'hA, "R5 second location");
    do_op(0, 1, 0, 0, 3, 32'h0, 4'h0, "R3 read back word 3");
    do_op(0, 1, 0, 0, 7, 32'h0, 4'h0, "R3 read back word 7");
  endtask

  task automatic t_mixed_ab;
    for (int s = 0; s < 4; s++) do_op(1, 1, 0, 0, 3 * 4 + s, 32'h0, 4'h0, "R1 narrow slice of wide word");
    do_op(1, 1, 1, 0, 7 * 4 + 2, 32'h5E, 4'h0, "R4 write-first shows written byte");
    do_op(1, 1, 1, 0, 7 * 4 + 0, 32'hA1, 4'h1, "R4 write-first with parity");
    do_op(0, 1, 0, 0, 7, 32'h0, 4'h0, "R1 wide read of narrow writes");
    do_op(1, 1, 0, 0, 7 * 4 + 3, 32'h0, 4'h0, "R2 9-bit parity slice");
  endtask

  task automatic t_enable;
    do_op(0, 0, 1, 0, 3, 32'hFFFF_FFFF, 4'hF, "R7 disabled write leaves output");
    do_op(0, 1, 0, 0, 3, 32'h0, 4'h0, "R7 disabled write left memory");
    do_op(1, 0, 0, 1, 5, 32'h0, 4'h0, "R7 disabled reset has no effect");
  endtask

  task automatic t_ssr;
    do_op(0, 1, 0, 1, 7, 32'h0, 4'h0, "R8 reset beats read");
    do_op(1, 1, 0, 1, 9, 32'h0, 4'h0, "R8 reset narrow port");
    do_op(0, 1, 0, 0, 7, 32'h0, 4'h0, "R8 memory intact after reset");
  endtask

  task automatic t_polarity;
    logic [35:0] want;
    do_op(0, 1, 1, 0, 5, 32'h8877_6655, 4'h6, "R9 setup write");
    want = get(refm[0][5], 9, 2);
    @(negedge clk); #1;
    drive(1, 1, 0, 0, 5 * 4 + 2, 32'h0, 4'h0);
    @(posedge clk); #1;
    chk("R9 falling port ignores rising edge", rd_act(1), expo[1]);
    @(negedge clk); #1;
    drive(1, 0, 0, 0, 5 * 4 + 2, 32'h0, 4'h0);
    expo[1] = want;
    chk("R9 falling port loads on falling edge", rd_act(1), want);
  endtask

  task automatic t_dut2;
    do_op(2, 1, 1, 0, 10 * 8 + 5, 32'h9, 4'h1, "R6 no-change write keeps output");
    do_op(2, 1, 1, 0, 10 * 8 + 0, 32'h3, 4'h0, "R6 no-change second write");
    do_op(2, 1, 0, 0, 10 * 8 + 5, 32'h0, 4'h0, "R2 narrow parity out is 0 after read");
    do_op(3, 1, 0, 0, 10 * 2 + 1, 32'h0, 4'h0, "R1 18-bit upper half from 4-bit writes");
    do_op(3, 1, 1, 0, 10 * 2 + 0, 32'h7E81, 4'h3, "R5 18-bit read-first old half");
    do_op(2, 1, 0, 0, 10 * 8 + 2, 32'h0, 4'h0, "R1 4-bit slice of 18-bit write");
    do_op(3, 1, 0, 0, 10 * 2 + 0, 32'h0, 4'h0, "R2 18-bit parity readback");
    do_op(2, 1, 0, 1, 0, 32'h0, 4'h0, "R8 4-bit port reset");
  endtask

  task automatic t_concurrent;
    int ia = 12, ib = 13;
    chk("R11 concurrent ops use distinct words", 36'(ia != ib), 36'd1);
    fork
      do_op(0, 1, 1, 0, ia, 32'h0BAD_F00D, 4'h5, "R5 concurrent A write");
      do_op(1, 1, 1, 0, ib * 4 + 1, 32'h77, 4'h1, "R4 concurrent B write");
    join
    do_op(0, 1, 0, 0, ib, 32'h0, 4'h0, "R11 A sees B word");
    do_op(1, 1, 0, 0, ia * 4 + 3, 32'h0, 4'h0, "R11 B sees A word");
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin refm[0][i] = '0; refm[1][i] = '0; end
    for (int p = 0; p < 4; p++) expo[p] = RSTV[p];
    #1;
    t_reset_state();
    t_wide_rw();
    t_mixed_ab();
    t_enable();
    t_ssr();
    t_polarity();
    t_dut2();
    t_concurrent();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule